// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the stream of column addresses that a DRAM-style burst visits. A caller presents a start column together with the two configuration settings, burst length and word order, and pulses a start input. From the next clock on, the block puts out one column per cycle with a valid flag. It raises a last flag alongside the final column of the burst.

Every column in a burst lies in the aligned group of BL words that contains the start column, and the start column itself always comes out first. In linear order the offset inside the group counts upward from the start offset and wraps at the group edge. In interleaved order the offset is the start offset XORed with the word index. The two configuration settings are held as mode state: they are captured only when a burst is accepted, and a request made while a burst is still running is dropped. A request that coincides with the last word is taken, so bursts can follow each other with no gap.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, valid_o and last_o are 0. last_o is never 1 unless valid_o is 1.
- R2: When a start is accepted, the next cycle has valid_o = 1 and col_o equal to the start column, in both orders.
- R3: Length code 0, 1, 2 or 3 gives a burst of 1, 2, 4 or 8 words. The words come on consecutive cycles, and last_o is 1 on the final word only.
- R4: In linear order (order bit 0), word k has offset (s + k) mod BL inside the group, where s is the start column mod BL. For example, start 5 with 4 words gives 5, 6, 7, 4.
- R5: In interleaved order (order bit 1), word k has offset s XOR k inside the group. For example, start 5 with 8 words gives 5, 4, 7, 6, 1, 0, 3, 2.
- R6: For the whole burst, the column bits above the low log2(BL) bits equal those of the start column.
- R7: A 1-word burst returns only the start column. In a 2-word burst the second word is the other member of the aligned pair, whatever the order bit.
- R8: A start column that is a multiple of BL gives offsets 0, 1, ..., BL-1 in both orders.
- R9: A start that arrives while valid_o = 1 and last_o = 0 is ignored. A start that arrives while last_o = 1 is accepted, and the new burst's first word follows the old last word directly. With no start pending after the last word, valid_o drops to 0 on the next cycle.
- R10: The length code and order bit are sampled only when a start is accepted. Changing them during a burst does not alter the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Burst request pulse |
| start_col_i | input | COL_W | Start column of the burst |
| cfg_len_i | input | LEN_W | Burst length code: BL = 2^code |
| cfg_order_i | input | 1 | Word order: 0 linear wrap, 1 interleaved |
| col_o | output | COL_W | Current column address |
| valid_o | output | 1 | col_o holds a burst word |
| last_o | output | 1 | Final word of the burst |

## Verification
The bound checker tests these rules on every cycle: the first word equals the accepted start column, last_o appears exactly on word BL-1 of the captured length, the bits above the group stay fixed while a burst runs, and a request made mid-burst never restarts the word index. The exact word order cannot be checked this way. Linear wrap versus XOR order, the aligned ascending case, the effect of changing the configuration during a burst, back-to-back bursts and the drop of valid_o afterwards are shown only by the bench. The bench sweeps every start offset in the group, both orders and all four lengths, with two different values in the upper column bits.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } word_order_e;

endpackage

// File: rtl/burst_order_calc.sv
module burst_order_calc
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int CNT_W = 3,
  parameter int LEN_W = 2
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [CNT_W-1:0] idx,
  input  logic [LEN_W-1:0] len_code,
  input  word_order_e      order,
  output logic [COL_W-1:0] col
);

  localparam int PAD_W = COL_W - CNT_W;

  logic [COL_W-1:0] grp_mask;
  logic [COL_W-1:0] idx_x;
  logic [COL_W-1:0] low_any;

  always_comb begin
    grp_mask = ~({COL_W{1'b1}} << len_code);
    idx_x    = {{PAD_W{1'b0}}, idx};
    if (order == ORD_XOR) low_any = base_col ^ idx_x;
    else                  low_any = base_col + idx_x;
    col = (base_col & ~grp_mask) | (low_any & grp_mask);
  end

endmodule

// File: rtl/burst_step_ctrl.sv
module burst_step_ctrl #(
  parameter int CNT_W = 3,
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len_new,
  input  logic [LEN_W-1:0] len_held,
  output logic             accept,
  output logic             load,
  output logic [CNT_W-1:0] idx_nx,
  output logic             busy_q,
  output logic             fin_q
);

  logic [CNT_W-1:0] idx_q;
  logic             advance;
  logic [LEN_W-1:0] len_eff;
  logic [CNT_W-1:0] idx_lim;

  always_comb begin
    accept  = start && (!busy_q || fin_q);
    advance = busy_q && !fin_q;
    load    = accept || advance;
    idx_nx  = accept ? '0 : idx_q + 1'b1;
    len_eff = accept ? len_new : len_held;
    idx_lim = ~({CNT_W{1'b1}} << len_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      idx_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      fin_q  <= (idx_nx == idx_lim);
      idx_q  <= idx_nx;
    end else begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int MAX_BL = 8,
  localparam int CNT_W = $clog2(MAX_BL),
  localparam int LEN_W = $clog2(CNT_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic             cfg_order_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  logic             accept;
  logic             load;
  logic [CNT_W-1:0] idx_nx;
  logic [COL_W-1:0] base_q;
  logic [LEN_W-1:0] len_q;
  word_order_e      order_q;
  logic [COL_W-1:0] base_sel;
  logic [LEN_W-1:0] len_sel;
  word_order_e      order_sel;
  logic [COL_W-1:0] col_nx;

  burst_step_ctrl #(
    .CNT_W(CNT_W),
    .LEN_W(LEN_W)
  ) step_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start_i),
    .len_new (cfg_len_i),
    .len_held(len_q),
    .accept  (accept),
    .load    (load),
    .idx_nx  (idx_nx),
    .busy_q  (valid_o),
    .fin_q   (last_o)
  );

  always_comb begin
    base_sel  = accept ? start_col_i : base_q;
    len_sel   = accept ? cfg_len_i : len_q;
    order_sel = accept ? word_order_e'(cfg_order_i) : order_q;
  end

  burst_order_calc #(
    .COL_W(COL_W),
    .CNT_W(CNT_W),
    .LEN_W(LEN_W)
  ) calc_i (
    .base_col(base_sel),
    .idx     (idx_nx),
    .len_code(len_sel),
    .order   (order_sel),
    .col     (col_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      len_q   <= '0;
      order_q <= ORD_LINEAR;
      col_o   <= '0;
    end else begin
      if (accept) begin
        base_q  <= start_col_i;
        len_q   <= cfg_len_i;
        order_q <= word_order_e'(cfg_order_i);
      end
      if (load) col_o <= col_nx;
    end
  end

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W  = 10,
  parameter int MAX_BL = 8,
  localparam int CNT_W = $clog2(MAX_BL),
  localparam int LEN_W = $clog2(CNT_W + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [LEN_W-1:0] cfg_len_i,
  input logic             cfg_order_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);

  logic             acc_seen;
  logic [CNT_W-1:0] word_ix;
  logic [LEN_W-1:0] len_cap;
  logic [CNT_W-1:0] ix_lim;
  logic [COL_W-1:0] hi_mask;

  assign acc_seen = start_i && (!valid_o || last_o);
  assign ix_lim   = ~({CNT_W{1'b1}} << len_cap);
  assign hi_mask  = {COL_W{1'b1}} << len_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_ix <= '0;
      len_cap <= '0;
    end else if (acc_seen) begin
      word_ix <= '0;
      len_cap <= cfg_len_i;
    end else if (valid_o && !last_o) begin
      word_ix <= word_ix + 1'b1;
    end
  end

  // R1
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  // R2
  first_word_chk: assert property (@(posedge clk) disable iff (rst)
    acc_seen |=> (valid_o && col_o == $past(start_col_i)));

  // R3
  last_position_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (last_o == (word_ix == ix_lim)));

  // R6
  group_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o) |=> (((col_o ^ $past(col_o)) & hi_mask) == '0));

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o) |=> (valid_o && word_ix == $past(word_ix) + 1'b1));

endmodule

bind burst_col_gen burst_col_gen_chk #(
  .COL_W (COL_W),
  .MAX_BL(MAX_BL)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .start_col_i(start_col_i),
  .cfg_len_i  (cfg_len_i),
  .cfg_order_i(cfg_order_i),
  .col_o      (col_o),
  .valid_o    (valid_o),
  .last_o     (last_o)
);

// File: tb/burst_col_gen_tb_top.sv
`timescale 1ns/1ps
module burst_col_gen_tb_top;

  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [1:0]       cfg_len_i = '0;
  logic             cfg_order_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W), .MAX_BL(8)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .cfg_len_i(cfg_len_i), .cfg_order_i(cfg_order_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_col(int s, int len, int ord, int k);
    int bl   = 1 << len;
    int base = s - (s % bl);
    int off  = s % bl;
    if (ord != 0) return base + (off ^ k);
    return base + ((off + k) % bl);
  endfunction

  task automatic run_burst(input int s, input int len, input int ord, input bit noisy);
    int bl = 1 << len;
    start_i     = 1'b1;
    start_col_i = COL_W'(s);
    cfg_len_i   = 2'(len);
    cfg_order_i = ord[0];
    @(negedge clk);
    for (int k = 0; k < bl; k++) begin
      int e = expect_col(s, len, ord, k);
      string tag;
      if (k == 0) tag = "R2";
      else if (noisy) tag = "R10";
      else if (bl <= 2) tag = "R7";
      else if (ord != 0) tag = "R5";
      else tag = "R4";
      check(valid_o == 1'b1, "R3", int'(valid_o), 1);
      check(int'(col_o) == e, tag, int'(col_o), e);
      check((int'(col_o) >> len) == (s >> len), "R6", int'(col_o) >> len, s >> len);
      if (s % bl == 0)
        check(int'(col_o) % bl == k, "R8", int'(col_o) % bl, k);
      check(last_o == (k == bl - 1), "R3", int'(last_o), int'(k == bl - 1));
      if (noisy && k < bl - 1) begin
        start_i     = 1'b1;
        start_col_i = ~COL_W'(s);
        cfg_len_i   = ~2'(len);
        cfg_order_i = ~ord[0];
      end else begin
        start_i = 1'b0;
      end
      if (k < bl - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0 && last_o == 1'b0, "R1", int'({valid_o, last_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(valid_o == 1'b0 && last_o == 1'b0, "R1", int'({valid_o, last_o}), 0);
    for (int ord = 0; ord < 2; ord++)
      for (int len = 0; len < 4; len++)
        for (int up = 0; up < 2; up++)
          for (int off = 0; off < 8; off++) begin
            int s = (up != 0 ? 10'h3A8 : 10'h150) | off;
            run_burst(s, len, ord, off[0]);
            if (!off[1]) begin
              @(negedge clk);
              check(valid_o == 1'b0, "R9", int'(valid_o), 0);
            end
          end
    // explicit sequences from the requirement examples
    run_burst(5, 2, 0, 1'b0);
    run_burst(5, 3, 1, 1'b0);
    @(negedge clk);
    check(valid_o == 1'b0 && last_o == 1'b0, "R9", int'({valid_o, last_o}), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule